// File: doc/BRIEF.md
# Memory Tag Check Unit

This block guards memory accesses with lock-and-key tags. Memory is split into 16-byte granules, and the unit keeps a 4-bit lock tag for each granule in a small tag RAM. Every pointer carries a 4-bit key in its upper byte. For each load or store the unit compares that key with the lock of every granule the access touches. The data memory and address translation sit outside the block. The unit reports through a response whether the access may go ahead.

An allocator path retags an allocation with a single command. The command gives a first granule, a granule count and a tag. The unit then writes one granule per cycle and holds `busy` high while it does so. After retagging, a stale pointer that still carries the old key fails the check.

A mismatch is handled in one of two ways. In synchronous mode the access is blocked and answered with an error. In asynchronous mode the access goes ahead, and a sticky flag and the first offending pointer are recorded until software clears them.

Top module: `mtag_unit`

## Requirements
- R1: Granules are 16 bytes, each with a 4-bit tag. The granule index is taken from pointer bits [GIDX_W+3:4] and wraps modulo the number of granules. Pointer bits [63:56] never take part in selecting a granule, so junk in bits [63:60] has no effect.
- R2: The key is pointer bits [59:56]. When the key equals the tag of every granule the access touches, the response has `rsp_err`=0 and `rsp_perform`=1.
- R3: An access is accepted on a rising edge where `acc_valid`=1 and `acc_ready`=1. Its response (`rsp_valid`, `rsp_err`, `rsp_perform`, `rsp_write`) appears right after that same edge and lasts one cycle.
- R4: In synchronous mode (`mode_async`=0, sampled at acceptance), a mismatch gives `rsp_err`=1 and `rsp_perform`=0, so a store is not performed and a load is answered with an error. The status register is not touched.
- R5: In asynchronous mode (`mode_async`=1), a mismatch gives `rsp_err`=0 and `rsp_perform`=1, and sets `stat_fault`.
- R6: `stat_addr` holds the full 64-bit pointer of the first asynchronous mismatch. `stat_fault` and `stat_addr` hold their values through later mismatches until they are cleared.
- R7: `stat_clear`=1 clears `stat_fault` and `stat_addr` to zero. If an asynchronous mismatch is accepted in the same cycle, the fault is recorded instead, with that access's pointer.
- R8: `acc_size` is log2 of the access length in bytes (0 to 4; codes above 4 mean 16 bytes). When an access crosses into the next granule, both tags are checked, and a mismatch in either one faults.
- R9: A tag-set command is accepted when `set_valid`=1 and `busy`=0. It writes `set_tag` to `set_count` granules, starting at `set_gran` and wrapping. It writes one granule per cycle, and `busy` is high for exactly `set_count` cycles starting after acceptance. A count of zero does nothing.
- R10: `acc_ready` is the inverse of `busy`. No access is accepted and no response is produced while `busy` is high. A `set_valid` raised while busy is ignored.
- R11: After retagging, a pointer carrying the old tag mismatches. If the new tag happens to equal the old tag, the access passes.
- R12: After reset all granule tags are 0, `busy`=0, `rsp_valid`=0, `stat_fault`=0 and `stat_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Tag-set command request |
| set_gran | input | GIDX_W | First granule index of the range |
| set_count | input | GIDX_W+1 | Number of granules to write |
| set_tag | input | 4 | Tag value to write |
| busy | output | 1 | Tag-set command in progress |
| acc_valid | input | 1 | Access request |
| acc_ptr | input | 64 | Tagged pointer |
| acc_size | input | 3 | log2 of access length in bytes |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_ready | output | 1 | Access can be accepted this cycle |
| mode_async | input | 1 | 1 selects asynchronous mismatch reporting |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Synchronous tag-check fault |
| rsp_perform | output | 1 | Access may proceed to data memory |
| rsp_write | output | 1 | Echo of the access direction |
| stat_clear | input | 1 | Clear the sticky status |
| stat_fault | output | 1 | Sticky asynchronous fault flag |
| stat_addr | output | 64 | Pointer of the first asynchronous fault |

## Verification
Each kind of corrupted internal state shows up at the ports on a known cycle:
- **Corrupted tag RAM entry or bad write sequencer:** the next access that touches that granule returns a wrong `rsp_err`/`rsp_perform` pair one cycle after acceptance. The sweeps of every granule against every key expose this on the first access to that granule.
- **Stuck or miscounted remaining-granule counter:** `busy` stays high too long or drops too early. The bench counts this cycle by cycle.
- **Broken sticky logic:** a later fault overwrites `stat_addr`, or the flag drops without a clear. Both are visible in the cycle after the second mismatch.

// File: rtl/mtag_pkg.sv
package mtag_pkg;

    localparam int TAG_W      = 4;
    localparam int GRAN_LG    = 4;
    localparam int PTR_W      = 64;
    localparam int KEY_LSB    = 56;
    localparam int SIZE_W     = 3;
    localparam int MAX_SIZE_LG = GRAN_LG;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic valid;
        logic err;
        logic perform;
        logic write;
    } rsp_t;

    function automatic tag_t key_of(input logic [PTR_W-1:0] p);
        return p[KEY_LSB +: TAG_W];
    endfunction

    // Byte span minus one of an access of 2**size_lg bytes, capped at one granule.
    function automatic logic [GRAN_LG:0] span_m1(input logic [SIZE_W-1:0] size_lg);
        logic [GRAN_LG:0] s;
        if (int'(size_lg) >= MAX_SIZE_LG)
            s = (GRAN_LG+1)'((1 << MAX_SIZE_LG) - 1);
        else
            s = (GRAN_LG+1)'((1 << size_lg) - 1);
        return s;
    endfunction

endpackage

// File: rtl/mtag_tag_store.sv
module mtag_tag_store
    import mtag_pkg::*;
#(
    parameter int GIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_valid,
    input  logic [GIDX_W-1:0] set_gran,
    input  logic [GIDX_W:0]   set_count,
    input  tag_t              set_tag,
    output logic              busy,
    input  logic [GIDX_W-1:0] rd_idx_lo,
    input  logic [GIDX_W-1:0] rd_idx_hi,
    output tag_t              rd_tag_lo,
    output tag_t              rd_tag_hi
);
    localparam int NGRAN = 1 << GIDX_W;

    tag_t              tags [NGRAN];
    logic [GIDX_W:0]   remain;
    logic [GIDX_W-1:0] wr_idx;
    tag_t              wr_tag;

    assign busy      = (remain != '0);
    assign rd_tag_lo = tags[rd_idx_lo];
    assign rd_tag_hi = tags[rd_idx_hi];

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            wr_idx <= '0;
            wr_tag <= '0;
        end else if (busy) begin
            wr_idx <= wr_idx + 1'b1;
            remain <= remain - 1'b1;
        end else if (set_valid) begin
            remain <= set_count;
            wr_idx <= set_gran;
            wr_tag <= set_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NGRAN; i++) tags[i] <= '0;
        end else if (busy) begin
            tags[wr_idx] <= wr_tag;
        end
    end

endmodule

// File: rtl/mtag_compare.sv
module mtag_compare
    import mtag_pkg::*;
#(
    parameter int GIDX_W = 6
) (
    input  logic [GIDX_W+GRAN_LG-1:0] addr_lo,
    input  logic [SIZE_W-1:0]         size_lg,
    input  tag_t                      key,
    input  tag_t                      tag_lo,
    input  tag_t                      tag_hi,
    output logic [GIDX_W-1:0]         idx_lo,
    output logic [GIDX_W-1:0]         idx_hi,
    output logic                      mismatch
);
    localparam int AW = GIDX_W + GRAN_LG;

    logic [AW-1:0] last_byte;

    always_comb begin
        last_byte = addr_lo + AW'(span_m1(size_lg));
        idx_lo    = addr_lo[GRAN_LG +: GIDX_W];
        idx_hi    = last_byte[GRAN_LG +: GIDX_W];
        mismatch  = (tag_lo != key) || (tag_hi != key);
    end

endmodule

// File: rtl/mtag_fault_log.sv
module mtag_fault_log
    import mtag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_evt,
    input  logic [PTR_W-1:0] fault_ptr,
    input  logic             clear,
    output logic             stat_fault,
    output logic [PTR_W-1:0] stat_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_fault <= 1'b0;
            stat_addr  <= '0;
        end else if (fault_evt) begin
            stat_fault <= 1'b1;
            if (!stat_fault || clear) stat_addr <= fault_ptr;
        end else if (clear) begin
            stat_fault <= 1'b0;
            stat_addr  <= '0;
        end
    end

endmodule

// File: rtl/mtag_unit.sv
module mtag_unit
    import mtag_pkg::*;
#(
    parameter int GIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_valid,
    input  logic [GIDX_W-1:0] set_gran,
    input  logic [GIDX_W:0]   set_count,
    input  logic [3:0]        set_tag,
    output logic              busy,
    input  logic              acc_valid,
    input  logic [63:0]       acc_ptr,
    input  logic [2:0]        acc_size,
    input  logic              acc_write,
    output logic              acc_ready,
    input  logic              mode_async,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_perform,
    output logic              rsp_write,
    input  logic              stat_clear,
    output logic              stat_fault,
    output logic [63:0]       stat_addr
);
    logic [GIDX_W-1:0] idx_lo, idx_hi;
    tag_t              tag_lo, tag_hi;
    logic              mismatch, accept, blocked;
    rsp_t              rsp_q;

    mtag_tag_store #(.GIDX_W(GIDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .set_valid (set_valid),
        .set_gran  (set_gran),
        .set_count (set_count),
        .set_tag   (set_tag),
        .busy      (busy),
        .rd_idx_lo (idx_lo),
        .rd_idx_hi (idx_hi),
        .rd_tag_lo (tag_lo),
        .rd_tag_hi (tag_hi)
    );

    mtag_compare #(.GIDX_W(GIDX_W)) u_cmp (
        .addr_lo  (acc_ptr[GIDX_W+GRAN_LG-1:0]),
        .size_lg  (acc_size),
        .key      (key_of(acc_ptr)),
        .tag_lo   (tag_lo),
        .tag_hi   (tag_hi),
        .idx_lo   (idx_lo),
        .idx_hi   (idx_hi),
        .mismatch (mismatch)
    );

    assign acc_ready = !busy;
    assign accept    = acc_valid && acc_ready;
    assign blocked   = mismatch && !mode_async;

    mtag_fault_log u_log (
        .clk        (clk),
        .rst        (rst),
        .fault_evt  (accept && mismatch && mode_async),
        .fault_ptr  (acc_ptr),
        .clear      (stat_clear),
        .stat_fault (stat_fault),
        .stat_addr  (stat_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid   <= accept;
            rsp_q.err     <= accept && blocked;
            rsp_q.perform <= accept && !blocked;
            rsp_q.write   <= accept && acc_write;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_err     = rsp_q.err;
    assign rsp_perform = rsp_q.perform;
    assign rsp_write   = rsp_q.write;

endmodule

// File: rtl/mtag_sva.sv
module mtag_sva (
    input logic        clk,
    input logic        rst,
    input logic        set_valid,
    input logic        busy,
    input logic        acc_valid,
    input logic        mode_async,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic        rsp_perform,
    input logic        stat_clear,
    input logic        stat_fault,
    input logic [63:0] stat_addr
);
    a_r3_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc_valid && !busy));

    a_r10_no_rsp_while_busy: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> !rsp_valid);

    a_r4_err_only_sync: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> !$past(mode_async));

    a_r4_err_excludes_perform: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_err != rsp_perform));

    a_r5_fault_needs_async: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_fault) |-> $past(mode_async && acc_valid && !busy));

    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_fault) && !$past(stat_clear)) |-> stat_fault);

    a_r6_addr_held: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_fault) && !$past(stat_clear)) |-> $stable(stat_addr));

    a_r9_busy_needs_set: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(set_valid));

endmodule

bind mtag_unit mtag_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .set_valid   (set_valid),
    .busy        (busy),
    .acc_valid   (acc_valid),
    .mode_async  (mode_async),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_perform (rsp_perform),
    .stat_clear  (stat_clear),
    .stat_fault  (stat_fault),
    .stat_addr   (stat_addr)
);

// File: tb/tb_mtag_unit.sv
`timescale 1ns/1ps
module tb_mtag_unit;
    localparam int GW = 6;
    localparam int NG = 1 << GW;

    logic          clk = 0, rst = 1;
    logic          set_valid = 0;
    logic [GW-1:0] set_gran = '0;
    logic [GW:0]   set_count = '0;
    logic [3:0]    set_tag = '0;
    logic          busy, acc_ready;
    logic          acc_valid = 0, acc_write = 0, mode_async = 0, stat_clear = 0;
    logic [63:0]   acc_ptr = '0;
    logic [2:0]    acc_size = '0;
    logic          rsp_valid, rsp_err, rsp_perform, rsp_write, stat_fault;
    logic [63:0]   stat_addr;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [3:0] model [NG];

    always #4 clk = ~clk;

    mtag_unit #(.GIDX_W(GW)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_mis(input logic [63:0] p, input int sz);
        int a, last, span;
        logic [3:0] key;
        span = (sz >= 4) ? 16 : (1 << sz);
        a    = int'(p[9:0]);
        last = a + span - 1;
        key  = p[59:56];
        return (model[(a >> 4) % NG] != key) || (model[(last >> 4) % NG] != key);
    endfunction

    // Drive one access; response sampled after the accepting edge.
    task automatic acc(input logic [63:0] p, input int sz, input bit wr, input bit asy,
                       input bit clr, input string req);
        bit m;
        m = exp_mis(p, sz);
        @(negedge clk);
        acc_valid = 1; acc_ptr = p; acc_size = 3'(sz); acc_write = wr;
        mode_async = asy; stat_clear = clr;
        @(negedge clk);
        acc_valid = 0; stat_clear = 0;
        chk(rsp_valid == 1, {req, " rsp_valid"}, 64'(rsp_valid), 1);
        chk(rsp_err == (m && !asy), {req, " rsp_err"}, 64'(rsp_err), 64'(m && !asy));
        chk(rsp_perform == !(m && !asy), {req, " rsp_perform"}, 64'(rsp_perform), 64'(!(m && !asy)));
        chk(rsp_write == wr, {req, " rsp_write"}, 64'(rsp_write), 64'(wr));
    endtask

    task automatic tagset(input int g, input int n, input logic [3:0] t);
        @(negedge clk);
        set_valid = 1; set_gran = GW'(g); set_count = (GW+1)'(n); set_tag = t;
        @(negedge clk);
        set_valid = 0;
        for (int k = 0; k < n; k++) begin
            chk(busy == 1 && acc_ready == 0, "R9 busy during set", 64'(busy), 1);
            @(negedge clk);
        end
        chk(busy == 0, "R9 busy ends after count", 64'(busy), 0);
        for (int k = 0; k < n; k++) model[(g + k) % NG] = t;
    endtask

    function automatic logic [63:0] mkptr(input int junk, input int key, input int g, input int off);
        return {4'(junk), 4'(key), 46'd0, 6'(g), 4'(off)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NG; i++) model[i] = 4'd0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk(busy == 0, "R12 busy", 64'(busy), 0);
        chk(rsp_valid == 0, "R12 rsp_valid", 64'(rsp_valid), 0);
        chk(stat_fault == 0, "R12 stat_fault", 64'(stat_fault), 0);
        chk(stat_addr == 0, "R12 stat_addr", stat_addr, 0);
        for (int g = 0; g < NG; g++) acc(mkptr(g, 0, g, 0), 0, 0, 0, 0, "R12 zero tags");

        // R9 one granule per command; R1 junk in top nibble
        for (int g = 0; g < NG; g++) tagset(g, 1, 4'((g * 5 + 3) % 16));

        // R1 R2 R4 sweep every granule against every key
        for (int g = 0; g < NG; g++)
            for (int t = 0; t < 16; t++)
                acc(mkptr((g + t) % 16, t, g, 0), g % 5, t % 2, 0, 0, "R2 R4 sweep");

        // R8 crossing accesses: 8 bytes at offset 12 touch g and g+1
        for (int g = 0; g < NG; g++) begin
            acc(mkptr(0, int'(model[g]), g, 12), 3, 0, 0, 0, "R8 cross key of low");
            acc(mkptr(0, int'(model[(g + 1) % NG]), g, 12), 3, 1, 0, 0, "R8 cross key of high");
        end
        tagset(10, 2, 4'd6);
        acc(mkptr(0, 6, 10, 8), 4, 0, 0, 0, "R8 cross both match");
        acc(mkptr(0, 6, 10, 15), 1, 0, 0, 0, "R8 cross 2-byte match");
        acc(mkptr(0, 6, 11, 15), 1, 0, 0, 0, "R8 cross into other tag");

        // R9 wrap and zero count
        tagset(62, 4, 4'd11);
        for (int g = 60; g < 66; g++) acc(mkptr(0, 11, g % NG, 0), 0, 0, 0, 0, "R9 wrap range");
        tagset(5, 0, 4'd15);
        acc(mkptr(0, int'(model[5]), 5, 0), 0, 0, 0, 0, "R9 zero count no effect");

        // R10 stall and ignored set while busy
        @(negedge clk);
        set_valid = 1; set_gran = GW'(20); set_count = 7'd5; set_tag = 4'd9;
        acc_valid = 1; acc_ptr = mkptr(0, 9, 20, 0); acc_size = 0; mode_async = 0;
        @(negedge clk);
        acc_valid = 0;
        chk(rsp_valid == 1, "R10 accept same cycle as set", 64'(rsp_valid), 1);
        set_gran = GW'(40); set_count = 7'd3; set_tag = 4'd1;
        acc_valid = 1;
        for (int k = 0; k < 5; k++) begin
            chk(busy == 1, "R10 busy", 64'(busy), 1);
            if (k == 1) set_valid = 0;
            @(negedge clk);
            chk(rsp_valid == 0, "R10 no response while busy", 64'(rsp_valid), 0);
        end
        set_valid = 0;
        acc_valid = 0;
        chk(busy == 0, "R10 busy drops", 64'(busy), 0);
        for (int k = 0; k < 5; k++) model[20 + k] = 4'd9;
        acc(mkptr(0, int'(model[40]), 40, 0), 0, 0, 0, 0, "R10 ignored set kept tag");
        acc(mkptr(0, 9, 24, 0), 0, 0, 0, 0, "R10 first set complete");

        // R11 stale pointer and same-tag retag
        tagset(30, 1, 4'd4);
        acc(mkptr(0, 4, 30, 0), 0, 1, 0, 0, "R11 fresh key");
        tagset(30, 1, 4'd7);
        acc(mkptr(0, 4, 30, 0), 0, 1, 0, 0, "R11 stale key faults");
        tagset(30, 1, 4'd7);
        acc(mkptr(0, 7, 30, 0), 0, 1, 0, 0, "R11 same tag passes");

        // R5 R6 R7 asynchronous status
        acc(mkptr(0, int'(model[3]), 3, 0), 0, 0, 1, 1, "R7 clear");
        chk(stat_fault == 0, "R7 cleared", 64'(stat_fault), 0);
        acc(mkptr(0, int'(model[3]) ^ 1, 3, 0), 0, 0, 0, 0, "R4 sync no status");
        chk(stat_fault == 0, "R4 sync leaves status", 64'(stat_fault), 0);
        acc(mkptr(3, int'(model[7]) ^ 2, 7, 4), 2, 1, 1, 0, "R5 async mismatch");
        chk(stat_fault == 1, "R5 sticky set", 64'(stat_fault), 1);
        chk(stat_addr == mkptr(3, int'(model[7]) ^ 2, 7, 4), "R6 first addr", stat_addr,
            mkptr(3, int'(model[7]) ^ 2, 7, 4));
        acc(mkptr(0, int'(model[8]) ^ 4, 8, 0), 0, 0, 1, 0, "R6 second mismatch");
        acc(mkptr(0, int'(model[8]), 8, 0), 0, 0, 1, 0, "R6 async match");
        chk(stat_addr == mkptr(3, int'(model[7]) ^ 2, 7, 4), "R6 addr kept", stat_addr,
            mkptr(3, int'(model[7]) ^ 2, 7, 4));
        chk(stat_fault == 1, "R6 flag kept", 64'(stat_fault), 1);
        acc(mkptr(0, int'(model[9]) ^ 8, 9, 0), 0, 0, 1, 1, "R7 clear with fault");
        chk(stat_fault == 1, "R7 fault wins", 64'(stat_fault), 1);
        chk(stat_addr == mkptr(0, int'(model[9]) ^ 8, 9, 0), "R7 new addr", stat_addr,
            mkptr(0, int'(model[9]) ^ 8, 9, 0));
        acc(mkptr(0, int'(model[9]), 9, 0), 0, 0, 1, 1, "R7 plain clear");
        chk(stat_fault == 0 && stat_addr == 0, "R7 cleared again", stat_addr, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule